// File: doc/BRIEF.md
# L3 Codec Control Byte Transmitter

This block sends one control byte at a time to an audio codec over a three-wire serial control bus. The bus has a clock line, a mode line and a data line. The host raises `start` for one cycle with an 8-bit value and a mode bit. The mode bit tells the codec how to read the byte: 0 marks an address byte and 1 marks a data byte. The block drives the mode line to the requested level and holds it through a programmable setup window. It then shifts the byte out least significant bit first, one bit for each serial clock period.

The serial clock is produced from the system clock. Each low phase and each high phase lasts `HALF_CYC` system cycles. The mode setup window lasts `SETUP_CYC` cycles. Its default of 40 cycles gives 200 ns at a 200 MHz system clock, which covers the codec's minimum of 190 ns.

After the eighth bit the block puts all three lines back to their idle levels and pulses `done` for one cycle. The idle levels are clock high, mode high and data low. While a byte is in flight, `busy` is high and any new `start` is ignored.

Top module: `l3w_ctl_tx`

## Requirements
- R1: After reset and after every transfer, with no transfer running, `ser_clk`=1, `ser_sel`=1, `ser_dat`=0 and `busy`=0.
- R2: A `start` seen while `busy`=0 begins a transfer. In the cycle after that edge, `busy`=1, `ser_clk`=1 and `ser_dat`=0.
- R3: With `ser_clk` high, the mode line holds its requested level for exactly `SETUP_CYC` cycles before the first falling edge of `ser_clk`. This is 40 cycles by default, which is 200 ns at 200 MHz.
- R4: Each transfer carries exactly 8 bits, least significant first. A new bit appears on `ser_dat` in the same cycle that `ser_clk` falls. It stays stable while `ser_clk` is high, so a receiver sampling on each rising edge rebuilds the byte.
- R5: Every low phase and every high phase of `ser_clk` lasts exactly `HALF_CYC` cycles. This includes the high phase after the eighth bit.
- R6: `busy` stays high for exactly `SETUP_CYC + 16*HALF_CYC` cycles. In the cycle it falls, `done`=1 for that one cycle only. In that same cycle `ser_sel` is forced to 1 and `ser_dat` to 0, whatever mode the byte used.
- R7: A `start` that arrives while `busy`=1 is ignored. The byte in flight and its mode level are unchanged, and no second transfer follows.
- R8: A synchronous, active-high `rst`, even in the middle of a transfer, returns the lines to their idle levels and clears `busy` and `done` at the next clock edge.
- R9: During a transfer the mode line equals the `mode_in` value captured at start. A value of 0 drives it low (address byte) and a value of 1 drives it high (data byte).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to send a byte |
| mode_in | input | 1 | Mode of the byte: 0 address, 1 data |
| byte_in | input | 8 | Byte to send |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse when a transfer ends |
| ser_clk | output | 1 | Serial bus clock line, idle high |
| ser_sel | output | 1 | Serial bus mode line, idle high |
| ser_dat | output | 1 | Serial bus data line, idle low |

## Verification
All outputs are registered, so the effect of a `start` or `rst` sampled at one edge is due in the cycle after that edge. The first falling edge of `ser_clk` is due `SETUP_CYC` cycles later. Each following serial edge is due `HALF_CYC` cycles after the previous one. `done` and the idle levels are due `SETUP_CYC + 16*HALF_CYC` cycles after the start edge.

The bench drives inputs and samples on the falling system clock edge, and counts sampled cycles from the start edge. It checks the setup run, every phase length and the total busy length against these counts, rebuilding the byte from the samples in which `ser_clk` has just risen.

// File: rtl/l3w_pkg.sv
package l3w_pkg;

   // sequencer phases of one control byte
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_SETUP = 2'd1,
      PH_LOW   = 2'd2,
      PH_HIGH  = 2'd3
   } l3w_phase_e;

   // bits carried by a single transfer
   localparam int unsigned L3W_BYTE_W = 8;

   function automatic int unsigned l3w_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/l3w_tick.sv
// Reloadable down-counter: after load with value N-1 it reports zero in the
// N-th following cycle, so a phase loaded this way lasts N cycles.
module l3w_tick #(
   parameter int unsigned MAXV = 40,
   localparam int unsigned CW = (MAXV > 1) ? $clog2(MAXV) : 1
) (
   input  logic          clk,
   input  logic          rst,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          zero
);

   if (MAXV < 1) begin : g_bad_max
      $error("l3w_tick: MAXV must be at least 1");
   end

   if (MAXV == 1) begin : g_trivial
      // every phase is one cycle long: no count needed
      assign zero = 1'b1;
   end else begin : g_count
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
         if (rst)
            cnt <= '0;
         else if (load)
            cnt <= load_val;
         else if (cnt != '0)
            cnt <= cnt - 1'b1;
      end
      assign zero = (cnt == '0);
   end

endmodule

// File: rtl/l3w_shreg.sv
// Right-shifting byte holder: presents the next bit LSB first and tracks
// how many bits remain.
module l3w_shreg #(
   parameter int unsigned W = 8,
   localparam int unsigned NW = $clog2(W + 1)
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         step,
   output logic         bit_o,
   output logic         empty_o
);

   logic [W-1:0]  sh;
   logic [NW-1:0] left;

   if (W < 1) begin : g_bad_w
      $error("l3w_shreg: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         sh   <= '0;
         left <= '0;
      end else if (load) begin
         sh   <= din;
         left <= NW'(W);
      end else if (step && (left != '0)) begin
         sh   <= sh >> 1;
         left <= left - 1'b1;
      end
   end

   assign bit_o   = sh[0];
   assign empty_o = (left == '0);

endmodule

// File: rtl/l3w_ctl_tx.sv
module l3w_ctl_tx #(
   parameter int unsigned HALF_CYC  = 4,
   parameter int unsigned SETUP_CYC = 40
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       start,
   input  logic       mode_in,
   input  logic [7:0] byte_in,
   output logic       busy,
   output logic       done,
   output logic       ser_clk,
   output logic       ser_sel,
   output logic       ser_dat
);
   import l3w_pkg::*;

   localparam int unsigned MAXV = l3w_max(HALF_CYC, SETUP_CYC);
   localparam int unsigned CW   = (MAXV > 1) ? $clog2(MAXV) : 1;
   localparam logic [CW-1:0] HALF_LD  = CW'(HALF_CYC - 1);
   localparam logic [CW-1:0] SETUP_LD = CW'(SETUP_CYC - 1);

   if (HALF_CYC < 1) begin : g_bad_half
      $error("l3w_ctl_tx: HALF_CYC must be at least 1");
   end
   if (SETUP_CYC < 1) begin : g_bad_setup
      $error("l3w_ctl_tx: SETUP_CYC must be at least 1");
   end

   l3w_phase_e    ph;
   logic          t_zero, t_load;
   logic [CW-1:0] t_val;
   logic          sh_bit, sh_empty, sh_load, sh_step;
   logic          accept, setup_end, low_end, high_end, more;

   assign accept    = (ph == PH_IDLE)  && start;
   assign setup_end = (ph == PH_SETUP) && t_zero;
   assign low_end   = (ph == PH_LOW)   && t_zero;
   assign high_end  = (ph == PH_HIGH)  && t_zero;
   assign more      = !sh_empty;

   always_comb begin
      t_load = 1'b0;
      t_val  = HALF_LD;
      if (accept) begin
         t_load = 1'b1;
         t_val  = SETUP_LD;
      end else if (setup_end || low_end || (high_end && more)) begin
         t_load = 1'b1;
         t_val  = HALF_LD;
      end
   end

   assign sh_load = accept;
   assign sh_step = setup_end || (high_end && more);

   l3w_tick #(.MAXV(MAXV)) u_tick (
      .clk      (clk),
      .rst      (rst),
      .load     (t_load),
      .load_val (t_val),
      .zero     (t_zero)
   );

   l3w_shreg #(.W(L3W_BYTE_W)) u_shreg (
      .clk     (clk),
      .rst     (rst),
      .load    (sh_load),
      .din     (byte_in),
      .step    (sh_step),
      .bit_o   (sh_bit),
      .empty_o (sh_empty)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         ph      <= PH_IDLE;
         busy    <= 1'b0;
         done    <= 1'b0;
         ser_clk <= 1'b1;
         ser_sel <= 1'b1;
         ser_dat <= 1'b0;
      end else begin
         done <= 1'b0;
         case (ph)
            PH_IDLE: begin
               if (start) begin
                  ph      <= PH_SETUP;
                  busy    <= 1'b1;
                  ser_clk <= 1'b1;
                  ser_sel <= mode_in;
                  ser_dat <= 1'b0;
               end
            end
            PH_SETUP: begin
               if (t_zero) begin
                  ph      <= PH_LOW;
                  ser_clk <= 1'b0;
                  ser_dat <= sh_bit;
               end
            end
            PH_LOW: begin
               if (t_zero) begin
                  ph      <= PH_HIGH;
                  ser_clk <= 1'b1;
               end
            end
            PH_HIGH: begin
               if (t_zero) begin
                  if (more) begin
                     ph      <= PH_LOW;
                     ser_clk <= 1'b0;
                     ser_dat <= sh_bit;
                  end else begin
                     ph      <= PH_IDLE;
                     busy    <= 1'b0;
                     done    <= 1'b1;
                     ser_sel <= 1'b1;
                     ser_dat <= 1'b0;
                  end
               end
            end
            default: ph <= PH_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/l3w_ctl_tx_chk.sv
module l3w_ctl_tx_chk #(
   parameter int unsigned SETUP_CYC = 40
) (
   input logic clk,
   input logic rst,
   input logic start,
   input logic busy,
   input logic done,
   input logic ser_clk,
   input logic ser_sel,
   input logic ser_dat
);

   // cycles of high clock seen in this transfer before its first falling edge
   int unsigned hi_cnt;
   logic        fell_seen;

   always_ff @(posedge clk) begin
      if (rst || !busy) begin
         hi_cnt    <= 0;
         fell_seen <= 1'b0;
      end else if (!ser_clk) begin
         fell_seen <= 1'b1;
      end else if (!fell_seen) begin
         hi_cnt <= hi_cnt + 1;
      end
   end

   a_r1_idle_lines: assert property (@(posedge clk) disable iff (rst)
      !busy |-> (ser_clk && ser_sel && !ser_dat));

   a_r2_start_takes: assert property (@(posedge clk) disable iff (rst)
      (start && !busy) |=> (busy && ser_clk && !ser_dat));

   a_r3_setup_window: assert property (@(posedge clk) disable iff (rst)
      (busy && !ser_clk && !fell_seen) |-> (hi_cnt >= SETUP_CYC));

   a_r4_data_held_high: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy) && ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

   a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
      done |=> !done);

   a_r6_done_at_end: assert property (@(posedge clk) disable iff (rst)
      done |-> (!busy && $past(busy)));

   a_r9_mode_held: assert property (@(posedge clk) disable iff (rst)
      (busy && $past(busy)) |-> $stable(ser_sel));

endmodule

bind l3w_ctl_tx l3w_ctl_tx_chk #(.SETUP_CYC(SETUP_CYC)) u_chk (
   .clk     (clk),
   .rst     (rst),
   .start   (start),
   .busy    (busy),
   .done    (done),
   .ser_clk (ser_clk),
   .ser_sel (ser_sel),
   .ser_dat (ser_dat)
);

// File: tb/l3w_ctl_tx_test.sv
`timescale 1ns/1ps
module l3w_ctl_tx_test;

   localparam int H = 4;
   localparam int S = 40;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       start = 1'b0;
   logic       mode_in = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic       busy, done, ser_clk, ser_sel, ser_dat;

   int total = 0;
   int bad   = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   l3w_ctl_tx #(.HALF_CYC(H), .SETUP_CYC(S)) uut (
      .clk(clk), .rst(rst), .start(start), .mode_in(mode_in), .byte_in(byte_in),
      .busy(busy), .done(done), .ser_clk(ser_clk), .ser_sel(ser_sel), .ser_dat(ser_dat)
   );

   // bit 8 = mode, bits 7:0 = byte
   localparam logic [8:0] VECS [0:5] = '{9'h001, 9'h180, 9'h0A5, 9'h15A, 9'h0FF, 9'h100};

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic chk_idle(input string req);
      chk(ser_clk === 1'b1 && ser_sel === 1'b1 && ser_dat === 1'b0 && busy === 1'b0,
          req, {busy, ser_clk, ser_sel, ser_dat}, 4'b0110);
   endtask

   task automatic run_xfer(input logic m, input logic [7:0] b, input bit intrude);
      int cyc = 1;
      int run = 1;
      int nbits = 0;
      int nfalls = 0;
      int setup = -1;
      int badlow = 0;
      int badhigh = 0;
      bit modebad = 0;
      logic prev = 1'b1;
      logic [7:0] got = 8'h00;
      @(negedge clk);
      start = 1'b1; mode_in = m; byte_in = b;
      @(negedge clk);
      start = 1'b0; mode_in = ~m; byte_in = ~b;
      chk(busy === 1'b1 && ser_clk === 1'b1 && ser_dat === 1'b0, "R2",
          {busy, ser_clk, ser_dat}, 3'b110);
      chk(ser_sel === m, "R9", ser_sel, m);
      forever begin
         @(negedge clk);
         cyc++;
         if (intrude && cyc == 20) start = 1'b1;
         if (intrude && cyc == 21) start = 1'b0;
         if (busy !== 1'b1 || cyc > 2000) break;
         if (ser_sel !== m) modebad = 1;
         if (ser_clk !== prev) begin
            if (prev == 1'b1) begin
               if (nfalls == 0) setup = run;
               else if (run != H) badhigh++;
               nfalls++;
            end else begin
               if (run != H) badlow++;
               got = {ser_dat, got[7:1]};
               nbits++;
            end
            run = 1;
            prev = ser_clk;
         end else begin
            run++;
         end
      end
      if (run != H) badhigh++;
      chk(setup == S, "R3", setup, S);
      chk(badlow == 0 && badhigh == 0, "R5", badlow + badhigh, 0);
      chk(nbits == 8, "R4", nbits, 8);
      chk(got == b, intrude ? "R7" : "R4", got, b);
      chk(!modebad, intrude ? "R7" : "R9", modebad, 0);
      chk(cyc - 1 == S + 16 * H, "R6", cyc - 1, S + 16 * H);
      chk(done === 1'b1, "R6", done, 1);
      chk_idle("R6");
      @(negedge clk);
      chk(done === 1'b0, "R6", done, 0);
      chk_idle("R1");
      if (intrude) begin
         repeat (5) @(negedge clk);
         chk(busy === 1'b0, "R7", busy, 0);
      end
   endtask

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      chk_idle("R1");
      chk(done === 1'b0, "R1", done, 0);

      foreach (VECS[i]) run_xfer(VECS[i][8], VECS[i][7:0], 1'b0);

      // R7: start during a transfer with different byte and mode
      run_xfer(1'b0, 8'h3C, 1'b1);

      // R8: reset in the middle of a transfer
      @(negedge clk);
      start = 1'b1; mode_in = 1'b0; byte_in = 8'h81;
      @(negedge clk);
      start = 1'b0;
      repeat (S + 10) @(negedge clk);
      chk(busy === 1'b1, "R8", busy, 1);
      rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk_idle("R8");
      chk(done === 1'b0, "R8", done, 0);

      // a normal transfer after the mid-transfer reset
      run_xfer(1'b1, 8'hC3, 1'b0);

      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule